// File: doc/BRIEF.md
# Delayed Inverter Hazard Model

This block is a clock-driven behavioural model of an inverting gate whose output lags its input. The gate keeps a held output bit and a mode: stable, unstable or hazard. While stable, the held bit is the inverse of the input. When the input comes to equal the held bit, the held output is now wrong and the model enters the unstable window. A settle strobe from the surrounding model closes that window: the held bit is inverted and the mode returns to stable.

If the input changes again while the model is unstable, the gate has been given a hazard. The model then latches into a hazard mode that only reset clears. In hazard mode, observed output values come from a free-running pseudo-random sequence, so the value is unpredictable but repeatable from run to run. An observe strobe samples the reported output one cycle later. The hazard flag and the mode code are visible at the ports.

Top module: `inv_hazard_model`

## Requirements
- R1: After synchronous reset, the mode is stable (`mode` = 2'd0), the held bit is 0, `hazard` is 0 and `obs_valid` is 0.
- R2: In stable mode, if `din` equals the held bit at a clock edge, the mode after that edge is unstable (`mode` = 2'd1).
- R3: In unstable mode, a `settle` strobe at an edge where `din` equals its value at the previous edge inverts the held bit and returns the mode to stable.
- R4: In unstable mode with no `settle` and no input change, the held bit and the mode stay as they are, and observe reports the old held bit.
- R5: In unstable mode, if `din` differs from its value sampled at the previous edge, the mode becomes hazard (`mode` = 2'd2) and `hazard` reads 1.
- R6: In hazard mode, each observed value is one bit of a free-running maximal-length 16-bit shift sequence, so any 17 consecutive observations contain both 0 and 1.
- R7: An `observe` strobe sampled at an edge sets `obs_valid` for the following cycle only. Outside hazard mode, `obs_value` then holds the held bit.
- R8: Hazard mode is sticky: `settle` and changes on `din` do not leave it, and only `rst` does.
- R9: When an input change and `settle` arrive at the same edge in unstable mode, the input change wins and the mode becomes hazard.
- R10: A `settle` strobe in stable mode has no effect on the mode or on the held bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Gate input level |
| settle | input | 1 | Strobe that lets the gate update its output |
| observe | input | 1 | Strobe that requests an output observation |
| obs_valid | output | 1 | Observation result is valid this cycle |
| obs_value | output | 1 | Observed output value |
| hazard | output | 1 | Model is in hazard mode |
| mode | output | 2 | Mode code: 0 stable, 1 unstable, 2 hazard |

## Verification
The two functions that can fall in the same cycle are the settle step and the detection of an input toggle, both while the model is unstable. The bench provokes this by entering the unstable window and then, at the very next edge, flipping `din` and raising `settle` together. The result is judged by the mode code after that edge, which must read hazard and not stable. Separate scenarios settle with a steady input, and toggle the input with no settle, so that each path is also seen on its own.

// File: rtl/ihz_pkg.sv
package ihz_pkg;

    localparam int LFSR_W = 16;
    // taps 16,14,13,11 of a maximal-length Fibonacci register
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED_DEF = 16'hACE1;

    typedef enum logic [1:0] {
        M_STABLE   = 2'd0,
        M_UNSTABLE = 2'd1,
        M_HAZARD   = 2'd2
    } mode_t;

    typedef struct packed {
        mode_t mode;
        logic  held;
    } gate_st_t;

    typedef struct packed {
        logic valid;
        logic value;
    } obs_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = ^(s & LFSR_TAPS);
        return {s[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/ihz_change_det.sv
module ihz_change_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic         changed
);
    logic [W-1:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= '0;
        else     sig_q <= sig;
    end

    assign changed = (sig != sig_q);

endmodule

// File: rtl/ihz_lfsr.sv
module ihz_lfsr
    import ihz_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = LFSR_SEED_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic rnd
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_step(state_q);
    end

    assign rnd = state_q[LFSR_W-1];

    // the register must never lock up in the all-zero state
    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/ihz_mode_fsm.sv
module ihz_mode_fsm
    import ihz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    input  logic     din_chg,
    input  logic     settle,
    output gate_st_t st
);
    gate_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            M_STABLE: begin
                if (din == st_q.held) st_d.mode = M_UNSTABLE;
            end
            M_UNSTABLE: begin
                if (din_chg) begin
                    st_d.mode = M_HAZARD;
                end else if (settle) begin
                    st_d.mode = M_STABLE;
                    st_d.held = ~st_q.held;
                end
            end
            default: st_d.mode = M_HAZARD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: M_STABLE, held: 1'b0};
        else     st_q <= st_d;
    end

    assign st = st_q;

    a_r2_enter_unstable: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_STABLE && din == st_q.held) |=> st_q.mode == M_UNSTABLE);

    a_r3_settle_flips: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_UNSTABLE && settle && !din_chg)
        |=> (st_q.mode == M_STABLE && st_q.held != $past(st_q.held)));

    a_r5_toggle_hazard: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_UNSTABLE && din_chg) |=> st_q.mode == M_HAZARD);

    a_r8_hazard_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_HAZARD) |=> st_q.mode == M_HAZARD);

    a_r10_stable_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_STABLE) |=> $stable(st_q.held));

endmodule

// File: rtl/ihz_observe.sv
module ihz_observe
    import ihz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     observe,
    input  gate_st_t st,
    input  logic     rnd,
    output obs_t     obs
);
    obs_t obs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            obs_q <= '0;
        end else begin
            obs_q.valid <= observe;
            if (observe)
                obs_q.value <= (st.mode == M_HAZARD) ? rnd : st.held;
        end
    end

    assign obs = obs_q;

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        observe |=> obs_q.valid);

    a_r7_valid_only_on_req: assert property (@(posedge clk) disable iff (rst)
        !observe |=> !obs_q.valid);

    a_r4_reports_held: assert property (@(posedge clk) disable iff (rst)
        (observe && st.mode != M_HAZARD) |=> obs_q.value == $past(st.held));

endmodule

// File: rtl/inv_hazard_model.sv
module inv_hazard_model
    import ihz_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = LFSR_SEED_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic       settle,
    input  logic       observe,
    output logic       obs_valid,
    output logic       obs_value,
    output logic       hazard,
    output logic [1:0] mode
);
    logic     din_chg;
    logic     rnd;
    gate_st_t st;
    obs_t     obs;

    ihz_change_det #(.W(1)) u_chg (
        .clk(clk), .rst(rst), .sig(din), .changed(din_chg)
    );

    ihz_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .rnd(rnd)
    );

    ihz_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .din(din), .din_chg(din_chg),
        .settle(settle), .st(st)
    );

    ihz_observe u_obs (
        .clk(clk), .rst(rst), .observe(observe), .st(st),
        .rnd(rnd), .obs(obs)
    );

    assign obs_valid = obs.valid;
    assign obs_value = obs.value;
    assign hazard    = (st.mode == M_HAZARD);
    assign mode      = st.mode;

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (mode == 2'd0 && !hazard && !obs_valid));

endmodule

// File: tb/tb_inv_hazard_model.sv
`timescale 1ns/1ps
module tb_inv_hazard_model;

    logic clk = 1'b0;
    logic rst, din, settle, observe;
    logic obs_valid, obs_value, hazard;
    logic [1:0] mode;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    inv_hazard_model dut (
        .clk(clk), .rst(rst), .din(din), .settle(settle), .observe(observe),
        .obs_valid(obs_valid), .obs_value(obs_value), .hazard(hazard), .mode(mode)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input int exp);
        chk(mode == exp[1:0], req, mode, exp);
    endtask

    task automatic do_observe(input string req, input int exp);
        observe = 1'b1;
        step();
        observe = 1'b0;
        chk(obs_valid == 1'b1, req, obs_valid, 1);
        chk(obs_value == exp[0], req, obs_value, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; din = 1'b1; settle = 1'b0; observe = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk_mode("R1 mode", 0);
        chk(hazard == 1'b0, "R1 hazard", hazard, 0);
        chk(obs_valid == 1'b0, "R1 obs_valid", obs_valid, 0);
        step();
        chk_mode("R1 stays stable with din=1", 0);
        do_observe("R1 held is 0", 0);
        step();
        chk(obs_valid == 1'b0, "R7 valid single cycle", obs_valid, 0);
    endtask

    // R10: settle in stable is ignored
    task automatic t_settle_stable();
        settle = 1'b1;
        step();
        settle = 1'b0;
        chk_mode("R10 mode after settle", 0);
        do_observe("R10 held unchanged", 0);
    endtask

    // R2, R4, R3: normal unstable window
    task automatic t_window();
        din = 1'b0;
        step();
        chk_mode("R2 unstable", 1);
        step();
        chk_mode("R4 still unstable", 1);
        do_observe("R4 old held value", 0);
        settle = 1'b1;
        step();
        settle = 1'b0;
        chk_mode("R3 back to stable", 0);
        do_observe("R3 held inverted", 1);
        chk_mode("R3 stays stable", 0);
    endtask

    // R5, R8, R6: hazard entry, stickiness, random reports
    task automatic t_hazard();
        int ones = 0;
        int zeros = 0;
        din = 1'b1;
        step();
        chk_mode("R2 unstable again", 1);
        din = 1'b0;
        step();
        chk_mode("R5 hazard mode", 2);
        chk(hazard == 1'b1, "R5 hazard flag", hazard, 1);
        settle = 1'b1;
        for (int i = 0; i < 4; i++) begin
            din = ~din;
            step();
            chk_mode("R8 sticky", 2);
        end
        settle = 1'b0;
        observe = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            chk(obs_valid == 1'b1, "R6 valid", obs_valid, 1);
            if (obs_value) ones++; else zeros++;
        end
        observe = 1'b0;
        chk(ones > 0, "R6 ones seen", ones, 1);
        chk(zeros > 0, "R6 zeros seen", zeros, 1);
        do_reset();
        chk_mode("R8 reset leaves hazard", 0);
        chk(hazard == 1'b0, "R8 flag cleared", hazard, 0);
    endtask

    // R9: settle and toggle together
    task automatic t_collide();
        din = 1'b0;
        step();
        chk_mode("R9 unstable", 1);
        din = 1'b1;
        settle = 1'b1;
        step();
        settle = 1'b0;
        chk_mode("R9 toggle beats settle", 2);
        chk(hazard == 1'b1, "R9 hazard flag", hazard, 1);
    endtask

    initial begin
        t_reset();
        t_settle_stable();
        t_window();
        t_hazard();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule